// File: doc/BRIEF.md
# Serial Management Interface Target

This block is the device-side end of the two-wire management bus. It runs on the management clock. It samples the data line on each rising clock edge and follows the frame bit by bit. A frame carries a start pattern, a two-bit operation code, a five-bit device address, a five-bit register address, a two-bit turnaround and sixteen data bits. All fields are sent most significant bit first. When the device address equals the strap value, a write frame produces a one-cycle write strobe on the register-file port. A read frame makes the block drive the register contents back onto the line.

The block answers nothing until it has been synchronised by an unbroken run of ones on the data line. After that, frames may follow one another with only idle ones between them. A malformed start, an unknown operation code or a bad write turnaround drops the block out of synchronisation. A fresh run of ones is then needed. The register file sits outside the block. The block gives it an address, write data and a write strobe, and reads back combinational read data.

Top module: `mdio_target`

## Requirements
- R1: While reset is asserted and after its release, the output enable is low and no write strobe is issued. Reset also clears synchronisation, so a frame that follows reset without a run of ones is ignored.
- R2: Until at least PRE_LEN (default 32) consecutive ones have been sampled, every frame is ignored. A run one short of that is not enough. A longer run is accepted.
- R3: Once synchronised, further frames need no run of ones. Any number of idle ones (including none) may separate them.
- R4: A frame is start `01`, opcode, device address, register address, turnaround, data. Each field is sent MSB first. Opcode `10` is read and `01` is write.
- R5: A start whose second bit is 0, or an opcode of `00` or `11`, loses synchronisation. The following frames are ignored until a new run of ones arrives.
- R6: On a write frame the turnaround must be `10`. Any other value cancels the write and loses synchronisation.
- R7: A write frame whose device address matches `strap_addr` raises `rf_wr_en` for exactly one cycle. This is the cycle after the edge that sampled the last data bit. During it, `rf_addr` holds the register address and `rf_wdata` holds the 16 data bits.
- R8: On a matching read, the output enable stays low during the first turnaround bit. The block drives 0 in the second turnaround bit. It then drives the 16 bits of `rf_rdata` for `rf_addr`, MSB first.
- R9: The output enable falls at the rising edge that ends the last read data bit, so the line is released for the next bit period.
- R10: A frame addressed to another device is neither written nor answered. It is still followed to its end, so the next frame is framed correctly without a run of ones.
- R11: `mdio_i` is sampled on the rising edge of `mdc`. `mdio_o` and `mdio_oe` change only just after that edge, so they are stable for the station's next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_addr | input | 5 | Device address this target answers to |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line driver |
| rf_addr | output | 5 | Register address of the current or last frame |
| rf_wr_en | output | 1 | One-cycle write strobe to the register file |
| rf_wdata | output | 16 | Write data for the register file |
| rf_rdata | input | 16 | Combinational read data for `rf_addr` |

## Verification
The bench targets these cases:
- A run of ones one bit short of the threshold. A design that counts one bit early would answer that frame.
- Each resync trigger (bad start, both illegal opcodes, both bad write turnarounds), followed by a frame without preamble. A design that stays synchronised would answer or write where it must stay silent.
- The exact read timing: silent first turnaround, driven zero, sixteen bits, then release one period later. An off-by-one shift or a late release shows up as wrong data or as contention on the line.
- Frames for other addresses mixed into back-to-back traffic. A design that stops tracking them would misframe the frame that follows.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_START = 3'd2,
    ST_OPC   = 3'd3,
    ST_ADDR  = 3'd4,
    ST_TURN  = 3'd5,
    ST_DATA  = 3'd6
  } frm_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_sync_count.sv
// Counts consecutive ones while the target is out of synchronisation.
module mdio_sync_count #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunting,
  input  logic bit_i,
  output logic sync_ok
);
  localparam int PW = $clog2(PRE_LEN + 1);

  logic [PW-1:0] ones_q, ones_d;

  always_comb begin
    ones_d = '0;
    if (hunting && bit_i) begin
      if (ones_q == PW'(PRE_LEN)) ones_d = ones_q;
      else                        ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assign sync_ok = (ones_q == PW'(PRE_LEN));

endmodule

// File: rtl/mdio_frame_fsm.sv
// Walks the frame fields one sampled bit at a time.
module mdio_frame_fsm
  import mdio_target_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              sync_ok,
  input  logic [PHY_AW-1:0] strap,
  output logic              hunting,
  output logic              is_read,
  output logic              phy_match,
  output logic [REG_AW-1:0] reg_addr,
  output logic              drv_load,
  output logic              drv_shift,
  output logic              drv_rel,
  output logic              wr_commit,
  output logic [DW-1:0]     wr_data
);
  localparam int AW    = PHY_AW + REG_AW;
  localparam int CMAX  = (DW > AW) ? DW : AW;
  localparam int CNT_W = $clog2(CMAX);

  frm_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       opc_q, opc_d;
  logic [AW-1:0]    adr_q, adr_d;
  logic [DW-1:0]    dat_q, dat_d;
  logic [1:0]       opc_nx;
  logic             last_dat;

  assign opc_nx    = {opc_q[0], bit_i};
  assign is_read   = (opc_q == OPC_READ);
  assign phy_match = (adr_q[AW-1:REG_AW] == strap);
  assign reg_addr  = adr_q[REG_AW-1:0];
  assign hunting   = (state_q == ST_HUNT);
  assign last_dat  = (state_q == ST_DATA) && (cnt_q == CNT_W'(DW - 1));

  assign drv_load  = (state_q == ST_TURN) && (cnt_q == '0) && is_read && phy_match;
  assign drv_shift = ((state_q == ST_TURN) && (cnt_q != '0)) ||
                     ((state_q == ST_DATA) && !last_dat);
  assign drv_rel   = last_dat;
  assign wr_commit = last_dat && !is_read && phy_match;
  assign wr_data   = {dat_q[DW-2:0], bit_i};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    adr_d   = adr_q;
    dat_d   = dat_q;
    unique case (state_q)
      ST_HUNT: begin
        if (!bit_i && sync_ok) state_d = ST_START;
      end
      ST_IDLE: begin
        if (!bit_i) state_d = ST_START;
      end
      ST_START: begin
        if (bit_i) begin
          state_d = ST_OPC;
          cnt_d   = '0;
        end else begin
          state_d = ST_HUNT;
        end
      end
      ST_OPC: begin
        opc_d = opc_nx;
        if (cnt_q == '0) begin
          cnt_d = CNT_W'(1);
        end else if (opc_nx == OPC_READ || opc_nx == OPC_WRITE) begin
          state_d = ST_ADDR;
          cnt_d   = '0;
        end else begin
          state_d = ST_HUNT;
        end
      end
      ST_ADDR: begin
        adr_d = {adr_q[AW-2:0], bit_i};
        if (cnt_q == CNT_W'(AW - 1)) begin
          state_d = ST_TURN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) begin
          if (!is_read && !bit_i) state_d = ST_HUNT;
          else                    cnt_d   = CNT_W'(1);
        end else begin
          if (!is_read && bit_i) begin
            state_d = ST_HUNT;
          end else begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end
        end
      end
      ST_DATA: begin
        dat_d = {dat_q[DW-2:0], bit_i};
        if (last_dat) state_d = ST_IDLE;
        else          cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      opc_q   <= '0;
      adr_q   <= '0;
      dat_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      adr_q   <= adr_d;
      dat_q   <= dat_d;
    end
  end

endmodule

// File: rtl/mdio_read_drv.sv
// Turnaround zero and read data shifter for the line driver.
module mdio_read_drv #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          rel_i,
  input  logic [DW-1:0] rdata,
  output logic          oe,
  output logic          dout
);
  localparam int RW = $clog2(DW + 2) + 1;

  logic [DW-1:0] sh_q, sh_d;
  logic          oe_q, oe_d;
  logic          o_q, o_d;

  always_comb begin
    sh_d = sh_q;
    oe_d = oe_q;
    o_d  = o_q;
    if (load) begin
      oe_d = 1'b1;
      o_d  = 1'b0;
      sh_d = rdata;
    end else if (oe_q) begin
      if (rel_i) begin
        oe_d = 1'b0;
      end else if (shift) begin
        o_d  = sh_q[DW-1];
        sh_d = {sh_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
      o_q  <= 1'b0;
    end else begin
      sh_q <= sh_d;
      oe_q <= oe_d;
      o_q  <= o_d;
    end
  end

  assign oe   = oe_q;
  assign dout = o_q;

  // Driving window: turnaround zero plus DW data bits, never longer.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (oe_q) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_drive_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (run_q <= RW'(DW)));

endmodule

// File: rtl/mdio_target.sv
module mdio_target
  import mdio_target_pkg::*;
#(
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [PHY_AW-1:0] strap_addr,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [REG_AW-1:0] rf_addr,
  output logic              rf_wr_en,
  output logic [DW-1:0]     rf_wdata,
  input  logic [DW-1:0]     rf_rdata
);
  logic rst_m_q, rst_s_q;
  logic hunting, sync_ok, is_read, phy_match;
  logic drv_load, drv_shift, drv_rel, wr_commit;
  logic [DW-1:0] wr_data;
  logic [REG_AW-1:0] reg_addr;
  logic wr_en_q;
  logic [DW-1:0] wdat_q, wdat_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  mdio_sync_count #(.PRE_LEN(PRE_LEN)) u_sync (
    .clk     (mdc),
    .rst_n   (rst_s_q),
    .hunting (hunting),
    .bit_i   (mdio_i),
    .sync_ok (sync_ok)
  );

  mdio_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW)) u_fsm (
    .clk       (mdc),
    .rst_n     (rst_s_q),
    .bit_i     (mdio_i),
    .sync_ok   (sync_ok),
    .strap     (strap_addr),
    .hunting   (hunting),
    .is_read   (is_read),
    .phy_match (phy_match),
    .reg_addr  (reg_addr),
    .drv_load  (drv_load),
    .drv_shift (drv_shift),
    .drv_rel   (drv_rel),
    .wr_commit (wr_commit),
    .wr_data   (wr_data)
  );

  mdio_read_drv #(.DW(DW)) u_drv (
    .clk   (mdc),
    .rst_n (rst_s_q),
    .load  (drv_load),
    .shift (drv_shift),
    .rel_i (drv_rel),
    .rdata (rf_rdata),
    .oe    (mdio_oe),
    .dout  (mdio_o)
  );

  always_comb begin
    wdat_d = wdat_q;
    if (wr_commit) wdat_d = wr_data;
  end

  always_ff @(posedge mdc or negedge rst_s_q) begin
    if (!rst_s_q) begin
      wr_en_q <= 1'b0;
      wdat_q  <= '0;
    end else begin
      wr_en_q <= wr_commit;
      wdat_q  <= wdat_d;
    end
  end

  assign rf_wr_en = wr_en_q;
  assign rf_wdata = wdat_q;
  assign rf_addr  = reg_addr;

  assert_quiet_unsynced_R2: assert property (@(posedge mdc) disable iff (!rst_s_q)
    hunting |-> (!mdio_oe && !rf_wr_en));
  assert_ta_drives_zero_R8: assert property (@(posedge mdc) disable iff (!rst_s_q)
    $rose(mdio_oe) |-> !mdio_o);
  assert_answer_own_read_R10: assert property (@(posedge mdc) disable iff (!rst_s_q)
    $rose(mdio_oe) |-> (is_read && phy_match));
  assert_single_strobe_R7: assert property (@(posedge mdc) disable iff (!rst_s_q)
    rf_wr_en |=> !rf_wr_en);
  assert_no_write_on_read_R8: assert property (@(posedge mdc) disable iff (!rst_s_q)
    mdio_oe |-> !rf_wr_en);

endmodule

// File: tb/test_mdio_target.sv
module test_mdio_target;
  localparam logic [4:0] STRAP = 5'h0A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_en, m_val;
  logic        line;
  logic        mdio_o, mdio_oe, rf_wr_en;
  logic [4:0]  rf_addr;
  logic [15:0] rf_wdata, rf_rdata;
  logic [15:0] regs [32];
  logic [15:0] shadow [32];

  int n_chk = 0, n_err = 0, wr_cnt = 0;
  logic [4:0]  last_a;
  logic [15:0] last_d;
  bit done = 0;

  // captured frame observations
  logic        any_oe, ta1_oe, ta2_oe, ta2_line, oe_after;
  logic [15:0] rd_bits;

  always #2 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);
  assign rf_rdata = regs[rf_addr];

  mdio_target i_mdio_target (
    .mdc(clk), .rst_n(rst_n), .strap_addr(STRAP), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rf_addr(rf_addr),
    .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  always @(negedge clk) begin
    if (rf_wr_en) begin
      regs[rf_addr] <= rf_wdata;
      wr_cnt <= wr_cnt + 1;
      last_a <= rf_addr;
      last_d <= rf_wdata;
    end
  end

  // {opcode, device address, register address, data}
  localparam logic [27:0] VEC [9] = '{
    {2'b01, 5'h0A, 5'h03, 16'h1234},
    {2'b01, 5'h0A, 5'h1F, 16'hABCD},
    {2'b10, 5'h0A, 5'h03, 16'h0000},
    {2'b10, 5'h0A, 5'h1F, 16'h0000},
    {2'b01, 5'h0B, 5'h03, 16'hFFFF},
    {2'b10, 5'h0A, 5'h03, 16'h0000},
    {2'b10, 5'h0B, 5'h03, 16'h0000},
    {2'b01, 5'h0A, 5'h00, 16'h8001},
    {2'b10, 5'h0A, 5'h00, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit en, input bit v, output logic ln, output logic oe);
    @(negedge clk);
    m_en = en;
    m_val = v;
    #1;
    ln = line;
    oe = mdio_oe;
  endtask

  task automatic idle(input int n);
    logic l, o;
    for (int i = 0; i < n; i++) send(1'b0, 1'b1, l, o);
  endtask

  task automatic frame(input bit lead0, input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rg, input logic [1:0] ta,
                       input logic [15:0] wd);
    logic l, o;
    bit rd;
    logic [13:0] hdr;
    rd = (op == 2'b10);
    hdr = {st, op, phy, rg};
    any_oe = 1'b0;
    if (lead0) begin send(1'b1, 1'b0, l, o); any_oe |= o; end
    for (int i = 0; i < pre; i++) begin send(1'b1, 1'b1, l, o); any_oe |= o; end
    for (int i = 13; i >= 0; i--) begin send(1'b1, hdr[i], l, o); any_oe |= o; end
    send(!rd, ta[1], l, o); ta1_oe = o; any_oe |= o;
    send(!rd, ta[0], l, o); ta2_oe = o; ta2_line = l; any_oe |= o;
    for (int i = 15; i >= 0; i--) begin send(!rd, wd[i], l, o); rd_bits[i] = l; any_oe |= o; end
    send(1'b0, 1'b1, l, o); oe_after = o;
  endtask

  task automatic good_read(input logic [4:0] rg, input string req);
    frame(1'b0, 0, 2'b01, 2'b10, STRAP, rg, 2'b11, 16'h0);
    chk(ta1_oe == 1'b0, {req, " R8 first turnaround undriven"}, ta1_oe, 0);
    chk(ta2_oe && !ta2_line, {req, " R8 second turnaround zero"}, {ta2_oe, ta2_line}, 2'b10);
    chk(rd_bits == shadow[rg], {req, " R8 read data"}, rd_bits, shadow[rg]);
    chk(oe_after == 1'b0, {req, " R9 release after last bit"}, oe_after, 0);
  endtask

  initial begin
    int w0;
    logic [27:0] v;
    for (int i = 0; i < 32; i++) begin regs[i] = 16'h0; shadow[i] = 16'h0; end
    m_en = 1'b0; m_val = 1'b1; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(mdio_oe == 1'b0 && rf_wr_en == 1'b0, "R1 outputs in reset", {mdio_oe, rf_wr_en}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(mdio_oe == 1'b0 && rf_wr_en == 1'b0, "R1 outputs after reset", {mdio_oe, rf_wr_en}, 0);

    // R2: one short of the threshold
    w0 = wr_cnt;
    frame(1'b1, 31, 2'b01, 2'b01, STRAP, 5'h05, 2'b10, 16'h5A5A);
    idle(1);
    chk(wr_cnt == w0, "R2 short run write ignored", wr_cnt - w0, 0);
    frame(1'b1, 31, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(any_oe == 1'b0, "R2 short run read ignored", any_oe, 0);

    // R2: exact threshold, then R3/R7 write and back-to-back read
    w0 = wr_cnt;
    frame(1'b1, 32, 2'b01, 2'b01, STRAP, 5'h05, 2'b10, 16'h5A5A);
    idle(1);
    chk(wr_cnt == w0 + 1, "R2 R7 write after full run", wr_cnt - w0, 1);
    chk(last_a == 5'h05 && last_d == 16'h5A5A, "R7 strobe address and data", {last_a, last_d}, {5'h05, 16'h5A5A});
    shadow[5] = 16'h5A5A;
    good_read(5'h05, "R3 R11");

    // R4 R10 table walk, no preamble between frames
    for (int k = 0; k < 9; k++) begin
      v = VEC[k];
      w0 = wr_cnt;
      if (v[27:26] == 2'b01) begin
        frame(1'b0, 0, 2'b01, 2'b01, v[25:21], v[20:16], 2'b10, v[15:0]);
        idle(1);
        if (v[25:21] == STRAP) begin
          chk(wr_cnt == w0 + 1 && last_d == v[15:0] && last_a == v[20:16], "R4 R7 table write", last_d, v[15:0]);
          shadow[v[20:16]] = v[15:0];
        end else begin
          chk(wr_cnt == w0, "R10 table foreign write", wr_cnt - w0, 0);
        end
      end else if (v[25:21] == STRAP) begin
        good_read(v[20:16], "R4 table");
      end else begin
        frame(1'b0, 0, 2'b01, 2'b10, v[25:21], v[20:16], 2'b11, 16'h0);
        chk(any_oe == 1'b0, "R10 table foreign read", any_oe, 0);
      end
    end

    // R5: illegal opcode 11, then frames without preamble are ignored
    frame(1'b0, 0, 2'b01, 2'b11, STRAP, 5'h05, 2'b10, 16'h0000);
    frame(1'b0, 0, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(any_oe == 1'b0, "R5 opcode 11 forces resync", any_oe, 0);
    w0 = wr_cnt;
    frame(1'b0, 0, 2'b01, 2'b01, STRAP, 5'h05, 2'b10, 16'h0F0F);
    idle(1);
    chk(wr_cnt == w0, "R5 write ignored after bad opcode", wr_cnt - w0, 0);

    // R5: illegal opcode 00
    frame(1'b1, 32, 2'b01, 2'b00, STRAP, 5'h05, 2'b10, 16'h0000);
    frame(1'b0, 0, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(any_oe == 1'b0, "R5 opcode 00 forces resync", any_oe, 0);

    // R2: longer run accepted; then R5 bad start pattern 00
    frame(1'b1, 40, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(ta2_oe && rd_bits == shadow[5], "R2 long run accepted", rd_bits, shadow[5]);
    frame(1'b0, 0, 2'b00, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    frame(1'b0, 0, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(any_oe == 1'b0, "R5 bad start forces resync", any_oe, 0);

    // R6: bad write turnaround 11 and 00
    frame(1'b1, 32, 2'b01, 2'b10, STRAP, 5'h1F, 2'b11, 16'h0);
    w0 = wr_cnt;
    frame(1'b0, 0, 2'b01, 2'b01, STRAP, 5'h05, 2'b11, 16'h0000);
    idle(1);
    chk(wr_cnt == w0, "R6 turnaround 11 write dropped", wr_cnt - w0, 0);
    frame(1'b0, 0, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(any_oe == 1'b0, "R6 turnaround 11 forces resync", any_oe, 0);
    frame(1'b1, 32, 2'b01, 2'b01, STRAP, 5'h05, 2'b00, 16'h0000);
    idle(1);
    chk(wr_cnt == w0, "R6 turnaround 00 write dropped", wr_cnt - w0, 0);
    frame(1'b1, 32, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(rd_bits == shadow[5], "R6 register unchanged", rd_bits, shadow[5]);

    // R1: reset drops synchronisation
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    frame(1'b1, 0, 2'b01, 2'b10, STRAP, 5'h05, 2'b11, 16'h0);
    chk(any_oe == 1'b0, "R1 reset requires new run", any_oe, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule